// File: doc/BRIEF.md
# Vector-Driven FIFO Word Unpacker

This block sits between a 32-bit transmit FIFO and a serial shifter. It takes one FIFO word at a time and cuts it into a series of small bit chunks of one to eight bits. Up to four packing descriptors control the cuts. Each descriptor gives a start bit, a walking direction, a chunk length and an end-of-word flag. The descriptors live in two 32-bit configuration inputs. Software builds them to match its word size and packing density, for example four 7-bit words per entry or one 23-bit word per entry.

The descriptors are applied one after another, starting with descriptor 0. Each one yields one chunk on a valid/ready output stream, together with the chunk's bit count and a flag marking the word's final chunk. A small state machine runs the block. It has two states: `ST_IDLE`, which waits for a word, and `ST_EMIT`, which offers chunks. Its transitions are:
- ACCEPT: `ST_IDLE` to `ST_EMIT` when a word is taken.
- HOLD: stay in `ST_EMIT` while the sink stalls.
- ADVANCE: stay in `ST_EMIT` and step to the next descriptor after a non-final chunk is taken.
- RETIRE: `ST_EMIT` to `ST_IDLE` once the final chunk is taken.

The configuration is captured together with the word, so software may reprogram it while a word is being emitted.

Top module: `fifo_word_unpacker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Descriptor 0 sits in `cfg_lo[9:0]`, descriptor 1 in `cfg_lo[19:10]`, descriptor 2 in `cfg_hi[9:0]` and descriptor 3 in `cfg_hi[19:10]`. Within a descriptor:
  - bit 0 is the end flag;
  - bits 3:1 hold the length minus one, so `out_nbits` = field + 1, in the range 1 to 8;
  - bit 4 is the direction;
  - bits 9:5 hold the start index.
- R3: With direction 1 (MSB first), `out_data[i]` = word[start - len + i] for i = 0..len, where len is the field value. The start bit is therefore the chunk's MSB. Word positions below 0 read as 0.
- R4: With direction 0 (LSB first), `out_data[i]` = word[start + i] for i = 0..len. Word positions above 31 read as 0.
- R5: Bits of `out_data` at and above `out_nbits` are 0.
- R6: Descriptors are applied in order, starting from 0 for every word, with exactly one chunk per output handshake.
- R7: The chunk from a descriptor whose end flag is set carries `out_last` = 1 and is the word's final chunk. Descriptors after it produce no chunk.
- R8: If descriptors 0 to 2 all have the end flag clear, descriptor 3 ends the word with `out_last` = 1, whatever its own flag says.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output holds `out_valid`, `out_data`, `out_nbits` and `out_last` unchanged.
- R10: `in_ready` is 0 from the cycle after a word is accepted until the final chunk has been taken. It is 1 in the cycle after that handshake. `in_ready` and `out_valid` are never both 1.
- R11: Changes to `cfg_lo`, `cfg_hi` or `in_data` after a word is accepted do not affect that word's chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lo | input | 32 | Descriptors 0 and 1 |
| cfg_hi | input | 32 | Descriptors 2 and 3 |
| in_valid | input | 1 | FIFO word offered |
| in_data | input | 32 | FIFO word |
| in_ready | output | 1 | Block takes a word this cycle |
| out_valid | output | 1 | Chunk offered |
| out_data | output | 8 | Chunk bits, right-aligned |
| out_nbits | output | 4 | Chunk bit count, 1 to 8 |
| out_last | output | 1 | Final chunk of the current word |
| out_ready | input | 1 | Sink takes the chunk |

## Verification
The assertions check the handshake rules on every cycle:
- output stability under stall;
- mutual exclusion of `in_ready` and `out_valid`;
- the return to idle right after the final chunk;
- the bit count range;
- zeroing of the bits above the count.

Only the bench scenarios can show the rest:
- that each chunk holds the right word bits for its start, direction and length;
- that descriptors run in order;
- that the end flag, or the fallback to descriptor 3, cuts the sequence at the right place;
- that reprogramming during a word has no effect.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

    localparam int UP_WORD_W   = 32;
    localparam int UP_CHUNK_W  = 8;
    localparam int UP_NUM_VEC  = 4;
    localparam int UP_VEC_W    = 10;
    localparam int UP_PER_REG  = 2;
    localparam int UP_POS_W    = $clog2(UP_WORD_W);
    localparam int UP_LEN_W    = $clog2(UP_CHUNK_W);
    localparam int UP_NBITS_W  = UP_LEN_W + 1;

    typedef struct packed {
        logic [UP_POS_W-1:0] start;
        logic                msb_first;
        logic [UP_LEN_W-1:0] len_m1;
        logic                stop;
    } slice_desc_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } unpack_state_e;

endpackage

// File: rtl/unpack_desc_decode.sv
module unpack_desc_decode
    import unpack_pkg::*;
#(
    parameter int NUM_VEC = UP_NUM_VEC,
    parameter int VEC_W   = UP_VEC_W,
    parameter int POS_W   = UP_POS_W,
    parameter int LEN_W   = UP_LEN_W
) (
    input  logic [NUM_VEC*VEC_W-1:0] raw_vecs,
    output slice_desc_t              desc [NUM_VEC],
    output logic [NUM_VEC-1:0]       ends_word
);

    // Descriptor field positions: stop at 0, length above it,
    // direction above length, start index in the top bits.
    localparam int DIR_BIT = LEN_W + 1;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        logic [VEC_W-1:0] raw;
        assign raw = raw_vecs[v*VEC_W +: VEC_W];

        always_comb begin
            desc[v].start     = raw[VEC_W-1 -: POS_W];
            desc[v].msb_first = raw[DIR_BIT];
            desc[v].len_m1    = raw[LEN_W:1];
            desc[v].stop      = raw[0];
        end

        // The final slot closes the word even without its flag.
        if (v == NUM_VEC - 1) begin : g_tail
            assign ends_word[v] = 1'b1;
        end else begin : g_body
            assign ends_word[v] = raw[0];
        end
    end

endmodule

// File: rtl/unpack_chunk_extract.sv
module unpack_chunk_extract
    import unpack_pkg::*;
#(
    parameter int WORD_W  = UP_WORD_W,
    parameter int CHUNK_W = UP_CHUNK_W,
    parameter int POS_W   = UP_POS_W,
    parameter int LEN_W   = UP_LEN_W,
    localparam int NB_W   = LEN_W + 1
) (
    input  logic [WORD_W-1:0]  word,
    input  slice_desc_t        desc,
    output logic [CHUNK_W-1:0] chunk,
    output logic [NB_W-1:0]    nbits
);

    int base_pos;
    int bit_pos;

    always_comb begin
        // MSB-first walks downward from start, so the chunk's lowest
        // bit sits len positions below it.
        if (desc.msb_first) begin
            base_pos = int'(desc.start) - int'(desc.len_m1);
        end else begin
            base_pos = int'(desc.start);
        end
        bit_pos = 0;
        chunk   = '0;
        for (int i = 0; i < CHUNK_W; i++) begin
            bit_pos = base_pos + i;
            if ((i <= int'(desc.len_m1)) && (bit_pos >= 0) && (bit_pos < WORD_W)) begin
                chunk[i] = word[bit_pos[POS_W-1:0]];
            end
        end
    end

    assign nbits = {1'b0, desc.len_m1} + NB_W'(1);

endmodule

// File: rtl/unpack_seq_fsm.sv
module unpack_seq_fsm
    import unpack_pkg::*;
#(
    parameter int NUM_VEC   = UP_NUM_VEC,
    localparam int VIDX_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              out_ready,
    input  logic              cur_ends,
    output logic              in_ready,
    output logic              out_valid,
    output logic              load_word,
    output logic [VIDX_W-1:0] vec_idx
);

    unpack_state_e     state_q, state_d;
    logic [VIDX_W-1:0] idx_q, idx_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin          // ACCEPT
                    state_d = ST_EMIT;
                    idx_d   = '0;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    if (cur_ends) begin      // RETIRE
                        state_d = ST_IDLE;
                        idx_d   = '0;
                    end else begin           // ADVANCE
                        idx_d   = idx_q + VIDX_W'(1);
                    end
                end                          // else HOLD
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load_word = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready  = 1'b1;
                load_word = in_valid;
            end
            ST_EMIT: begin
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b0;
            end
        endcase
    end

    assign vec_idx = idx_q;

endmodule

// File: rtl/fifo_word_unpacker.sv
module fifo_word_unpacker
    import unpack_pkg::*;
#(
    parameter int WORD_W    = UP_WORD_W,
    parameter int CHUNK_W   = UP_CHUNK_W,
    parameter int NUM_VEC   = UP_NUM_VEC,
    parameter int VEC_W     = UP_VEC_W,
    parameter int PER_REG   = UP_PER_REG,
    localparam int NB_W     = UP_NBITS_W,
    localparam int VIDX_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    localparam int USED_W   = PER_REG * VEC_W,
    localparam int RAW_W    = NUM_VEC * VEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  cfg_lo,
    input  logic [WORD_W-1:0]  cfg_hi,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic [CHUNK_W-1:0] out_data,
    output logic [NB_W-1:0]    out_nbits,
    output logic               out_last,
    input  logic               out_ready
);

    logic [2*WORD_W-1:0]           cfg_all;
    logic [RAW_W-1:0]              raw_now;
    logic [RAW_W-1:0]              raw_q;
    logic [WORD_W-1:0]             word_q;
    logic [2*(WORD_W-USED_W)-1:0]  cfg_unused;
    slice_desc_t                   desc [NUM_VEC];
    logic [NUM_VEC-1:0]            ends_word;
    slice_desc_t                   cur_desc;
    logic                          cur_ends;
    logic                          load_word;
    logic [VIDX_W-1:0]             vec_idx;

    assign cfg_all    = {cfg_hi, cfg_lo};
    assign cfg_unused = {cfg_hi[WORD_W-1:USED_W], cfg_lo[WORD_W-1:USED_W]};

    // Gather the descriptor slices out of the configuration registers.
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_gather
        localparam int REG_SEL = v / PER_REG;
        localparam int SLOT    = v % PER_REG;
        assign raw_now[v*VEC_W +: VEC_W] = cfg_all[REG_SEL*WORD_W + SLOT*VEC_W +: VEC_W];
    end

    // Word and descriptor snapshot taken on ACCEPT.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            raw_q  <= '0;
        end else if (load_word) begin
            word_q <= in_data;
            raw_q  <= raw_now;
        end
    end

    unpack_desc_decode #(
        .NUM_VEC (NUM_VEC),
        .VEC_W   (VEC_W),
        .POS_W   (UP_POS_W),
        .LEN_W   (UP_LEN_W)
    ) i_decode (
        .raw_vecs  (raw_q),
        .desc      (desc),
        .ends_word (ends_word)
    );

    assign cur_desc = desc[vec_idx];
    assign cur_ends = ends_word[vec_idx];

    unpack_chunk_extract #(
        .WORD_W  (WORD_W),
        .CHUNK_W (CHUNK_W),
        .POS_W   (UP_POS_W),
        .LEN_W   (UP_LEN_W)
    ) i_extract (
        .word  (word_q),
        .desc  (cur_desc),
        .chunk (out_data),
        .nbits (out_nbits)
    );

    unpack_seq_fsm #(
        .NUM_VEC (NUM_VEC)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .cur_ends  (cur_ends),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load_word (load_word),
        .vec_idx   (vec_idx)
    );

    assign out_last = cur_ends;

endmodule

// File: rtl/unpack_checker.sv
module unpack_checker #(
    parameter int CHUNK_W = 8,
    parameter int NB_W    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic [CHUNK_W-1:0] out_data,
    input logic [NB_W-1:0]    out_nbits,
    input logic               out_last,
    input logic               out_ready
);

    p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_nbits >= NB_W'(1)) && (out_nbits <= NB_W'(CHUNK_W)))
        else $error("count out of range");

    p_zero_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data >> out_nbits) == '0))
        else $error("bits above count not zero");

    p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> out_valid)
        else $error("word ended before final chunk");

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_nbits) && $stable(out_last)))
        else $error("output changed under stall");

    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid))
        else $error("in_ready and out_valid both high");

    p_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid))
        else $error("no return to idle after final chunk");

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && !in_ready))
        else $error("accepted word not emitted");

endmodule

bind fifo_word_unpacker unpack_checker #(
    .CHUNK_W (CHUNK_W),
    .NB_W    (NB_W)
) i_unpack_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_nbits (out_nbits),
    .out_last  (out_last),
    .out_ready (out_ready)
);

// File: tb/test_fifo_word_unpacker.sv
`timescale 1ns/1ps
module test_fifo_word_unpacker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_lo = '0;
    logic [31:0] cfg_hi = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic [3:0]  out_nbits;
    logic        out_last;
    logic        out_ready = 1'b0;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    logic [7:0] e_data [4];
    logic [3:0] e_nb   [4];
    logic       e_last [4];
    logic       e_dir  [4];
    logic       e_stop [4];
    int         e_cnt;

    always #2.5 clk = ~clk;

    fifo_word_unpacker i_fifo_word_unpacker (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_lo    (cfg_lo),
        .cfg_hi    (cfg_hi),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_nbits (out_nbits),
        .out_last  (out_last),
        .out_ready (out_ready)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [9:0] mkvec(input int start, input bit dir,
                                         input int len, input bit stop);
        return {start[4:0], dir, len[2:0], stop};
    endfunction

    // Expected chunk list, built from the descriptor layout (R2),
    // extraction rules (R3/R4) and word-ending rules (R7/R8).
    task automatic build_expect(input logic [31:0] w, input logic [31:0] lo,
                                input logic [31:0] hi);
        logic [9:0] d;
        int st, ln, p;
        e_cnt = 0;
        for (int v = 0; v < 4; v++) begin
            case (v)
                0: d = lo[9:0];
                1: d = lo[19:10];
                2: d = hi[9:0];
                default: d = hi[19:10];
            endcase
            st = int'(d[9:5]);
            ln = int'(d[3:1]);
            e_data[v] = '0;
            for (int i = 0; i <= ln; i++) begin
                p = d[4] ? (st - ln + i) : (st + i);
                if (p >= 0 && p < 32) e_data[v][i] = w[p];
            end
            e_nb[v]   = 4'(ln + 1);
            e_dir[v]  = d[4];
            e_stop[v] = d[0];
            e_last[v] = d[0] || (v == 3);
            e_cnt++;
            if (e_last[v]) break;
        end
    endtask

    task automatic run_word(input logic [31:0] w, input logic [31:0] lo,
                            input logic [31:0] hi, input int rdy_pct);
        int k;
        int guard;
        bit rdy;
        build_expect(w, lo, hi);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        cfg_lo   = lo;
        cfg_hi   = hi;
        out_ready = 1'b0;
        #1;
        chk("R10", "in_ready when idle", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        // R11: disturb inputs while the word is being emitted
        in_data = $urandom;
        cfg_lo  = $urandom;
        cfg_hi  = $urandom;
        k = 0;
        guard = 0;
        while (guard < 2000) begin
            guard++;
            #1;
            if (k == e_cnt) begin
                chk("R10", "in_ready after final chunk", 32'(in_ready), 32'd1);
                chk("R6", "no extra chunk", 32'(out_valid), 32'd0);
                break;
            end
            chk("R6", "chunk offered", 32'(out_valid), 32'd1);
            chk("R10", "in_ready low while emitting", 32'(in_ready), 32'd0);
            chk(e_dir[k] ? "R3" : "R4", "chunk data (R11 snapshot)", 32'(out_data), 32'(e_data[k]));
            chk("R2", "chunk bit count", 32'(out_nbits), 32'(e_nb[k]));
            chk("R5", "bits above count", 32'(out_data >> out_nbits), 32'd0);
            chk((k == 3 && !e_stop[k]) ? "R8" : "R7", "final-chunk flag",
                32'(out_last), 32'(e_last[k]));
            rdy = ($urandom % 100) < rdy_pct;
            out_ready = rdy;
            if (rdy) k++;
            // R9: a stalled chunk is rechecked against the same expectation
            @(negedge clk);
        end
        out_ready = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog run did not complete actual=1 expected=0");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        #1;
        chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
        chk("R1", "in_ready in reset", 32'(in_ready), 32'd1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "out_valid after reset", 32'(out_valid), 32'd0);
        chk("R1", "in_ready after reset", 32'(in_ready), 32'd1);

        // Four 7-bit words per entry, MSB first
        run_word(32'hA5C3_5A3C,
                 {12'h0, mkvec(14,1,6,0), mkvec(6,1,6,0)},
                 {12'h0, mkvec(30,1,6,1), mkvec(22,1,6,0)}, 100);
        // Two 15-bit words per entry, LSB first
        run_word(32'h1234_ABCD,
                 {12'h0, mkvec(8,0,6,0), mkvec(0,0,7,0)},
                 {12'h0, mkvec(24,0,6,1), mkvec(16,0,7,0)}, 60);
        // One 23-bit word, MSB first, stop on descriptor 2 (R7)
        run_word(32'h00F0_0F5A,
                 {12'h0, mkvec(14,1,7,0), mkvec(22,1,7,0)},
                 {12'h0, mkvec(0,1,0,0), mkvec(6,1,6,1)}, 50);
        // R7: stop on descriptor 0, rest ignored
        run_word(32'hDEAD_BEEF,
                 {12'h0, mkvec(3,0,7,1), mkvec(31,1,7,1)},
                 {12'h0, mkvec(5,0,2,1), mkvec(9,1,4,0)}, 100);
        // R8: no stop flag anywhere
        run_word(32'hCAFE_F00D,
                 {12'hFFF, mkvec(4,0,3,0), mkvec(28,1,3,0)},
                 {12'hABC, mkvec(17,0,5,0), mkvec(11,1,2,0)}, 70);
        // R3 below bit 0, R4 above bit 31
        run_word(32'hFFFF_FFFF,
                 {12'h0, mkvec(30,0,7,0), mkvec(2,1,7,0)},
                 {12'h0, mkvec(31,0,0,1), mkvec(0,1,0,0)}, 40);
        // R9: long stalls
        run_word(32'h8000_0001,
                 {12'h0, mkvec(24,0,7,0), mkvec(31,1,7,0)},
                 {12'h0, mkvec(0,0,7,0), mkvec(7,1,7,1)}, 15);

        for (int n = 0; n < 300; n++) begin
            run_word($urandom, $urandom, $urandom, 25 + int'($urandom % 76));
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule